// File: doc/BRIEF.md
# PLL Clock Mode Sequencer

This block decides which source mode drives the core clock: PLL powered off, PLL bypassed, or PLL multiplying. It holds three pieces of configuration: a 4-bit multiplier code, a pre-divide bit that selects divide by two or divide by one, and a power-off bit. A single-cycle write bus sets them.

The PLL itself is outside the block. A lock input stands in for it. That input passes through a synchronizer, and only its rising edges count. From the configuration and the lock state the block reports the active mode. It also reports the clock ratio against the input clock as a numerator and a denominator.

Every write is checked against the legal ordering of the configuration steps. Multiplier writes also need the protection-enable input to be high. A write that breaks an ordering rule leaves the configuration untouched and sets a sticky error flag. Software clears the flag by writing a one to it.

Top module: `pll_mode_seq`

## Requirements
- R1: After reset the outputs are: mode bypass (encoding 0 = off, 1 = bypass, 2 = PLL), multiplier 0, pre-divide 0, power-off 0, ratio 1/2, bypass_o 1, locked_o 0, err_o 0.
- R2: Address 0, bits 3:0 hold the multiplier code. Code 0 means bypass and codes 1 to 10 mean multiply by that value. In PLL mode ratio_num_o equals the code. In any other mode ratio_num_o is 1. ratio_den_o is 2 when the pre-divide bit is 0 and 1 when it is 1.
- R3: An accepted multiplier write clears locked_o, and the mode stays bypass until lock status returns. Lock status sets on the first rising edge of lock_in after that write. locked_o rises on the third rising clock edge after lock_in rises.
- R4: A write to address 0 while prot_en is 0 changes neither the multiplier nor the error flag.
- R5: A write of a multiplier code from 11 to 15 is ignored and sets err_o.
- R6: A write to address 0 while the pre-divide bit is 1 is ignored and sets err_o.
- R7: Address 1 holds the control bits: bit 0 is pre-divide and bit 1 is power-off. A write that sets bit 0 from 0 while locked_o is 0 is ignored as a whole and sets err_o.
- R8: A write that sets the power-off bit while the multiplier is nonzero is ignored as a whole and sets err_o. Power-off with the multiplier at 0 gives mode off, bypass_o 0 and ratio 1/den. A nonzero multiplier write while power-off is 1 is ignored and sets err_o.
- R9: err_o is sticky. A write with bit 0 set to address 2 clears it, and a write of 0 there leaves it set.
- R10: When an accepted multiplier write and a synchronized lock rising edge fall in the same cycle, the write wins. locked_o stays 0 until a later rising edge of lock_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Write address: 0 multiplier, 1 control, 2 error clear |
| bus_wdata | input | 8 | Write data |
| prot_en | input | 1 | Protection enable; multiplier writes need it high |
| lock_in | input | 1 | Lock indication from the PLL, asynchronous |
| mode_o | output | 2 | Active mode: 0 off, 1 bypass, 2 PLL |
| ratio_num_o | output | 4 | Ratio numerator against the input clock |
| ratio_den_o | output | 2 | Ratio denominator, 1 or 2 |
| bypass_o | output | 1 | High in bypass mode |
| locked_o | output | 1 | Lock status |
| err_o | output | 1 | Sticky ordering-violation flag |
| mult_o | output | 4 | Stored multiplier code |
| prediv_o | output | 1 | Stored pre-divide bit |
| pwroff_o | output | 1 | Stored power-off bit |

## Verification
The two events that can share one cycle are an accepted multiplier write and a synchronized rising edge of the lock input. The first clears lock status and the second would set it. The bench raises lock_in and places the multiplier write on the exact clock edge at which the edge reaches the end of the synchronizer. It then checks that locked_o stays 0 and the mode stays bypass for several cycles, and that a fresh lock pulse afterwards does bring the PLL mode in.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;
  localparam int MULT_W = 4;
  localparam logic [MULT_W-1:0] MULT_TOP = 4'd10;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_PLL    = 2'd2
  } clk_mode_e;

  // A multiplier code is legal when it is within the supported range.
  function automatic logic mult_code_ok(input logic [MULT_W-1:0] code);
    return code <= MULT_TOP;
  endfunction

  // Numerator of the core clock ratio: the code only in PLL mode.
  function automatic logic [MULT_W-1:0] ratio_num(input clk_mode_e m,
                                                  input logic [MULT_W-1:0] code);
    return (m == MODE_PLL) ? code : {{(MULT_W-1){1'b0}}, 1'b1};
  endfunction

  // Denominator: pre-divide bit 1 means divide by one.
  function automatic logic [1:0] ratio_den(input logic prediv);
    return prediv ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/pll_cfg_regs.sv
`timescale 1ns/1ps
module pll_cfg_regs
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 prot_en,
  input  logic                 lock_stat_i,
  output logic [MULT_W-1:0]    mult_q,
  output logic                 prediv_q,
  output logic                 pwroff_q,
  output logic                 err_q,
  output logic                 mult_acc_o
);
  localparam logic [ADDR_W-1:0] A_MULT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);

  logic              wr_mult, wr_ctrl, err_clr;
  logic [MULT_W-1:0] new_mult;
  logic              mult_bad, mult_viol;
  logic              pd_new, po_new, pd_set_early, po_set_early;
  logic              ctrl_bad, ctrl_acc, ctrl_viol;
  logic              viol_w;

  // Multiplier write: protection gate first, then the ordering rules.
  always_comb begin
    wr_mult    = bus_wr && (bus_addr == A_MULT) && prot_en;
    new_mult   = bus_wdata[MULT_W-1:0];
    mult_bad   = !mult_code_ok(new_mult) || prediv_q ||
                 (pwroff_q && (new_mult != '0));
    mult_acc_o = wr_mult && !mult_bad;
    mult_viol  = wr_mult && mult_bad;
  end

  // Control write: pre-divide needs lock, power-off needs a zero multiplier.
  always_comb begin
    wr_ctrl      = bus_wr && (bus_addr == A_CTRL);
    pd_new       = bus_wdata[0];
    po_new       = bus_wdata[1];
    pd_set_early = pd_new && !prediv_q && !lock_stat_i;
    po_set_early = po_new && !pwroff_q && (mult_q != '0);
    ctrl_bad     = pd_set_early || po_set_early;
    ctrl_acc     = wr_ctrl && !ctrl_bad;
    ctrl_viol    = wr_ctrl && ctrl_bad;
  end

  assign err_clr = bus_wr && (bus_addr == A_CLR) && bus_wdata[0];
  assign viol_w  = mult_viol || ctrl_viol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_q   <= '0;
      prediv_q <= 1'b0;
      pwroff_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (mult_acc_o) mult_q <= new_mult;
      if (ctrl_acc) begin
        prediv_q <= pd_new;
        pwroff_q <= po_new;
      end
      if (viol_w)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  // R4
  property p_protect;
    @(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MULT && !prot_en) |=> ($stable(mult_q) && $stable(err_q));
  endproperty
  protect_hold_chk: assert property (p_protect);

  // R5
  property p_reserved;
    @(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MULT && prot_en && bus_wdata[MULT_W-1:0] > MULT_TOP)
      |=> ($stable(mult_q) && err_q);
  endproperty
  reserved_code_chk: assert property (p_reserved);

  // R6
  property p_mult_prediv;
    @(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MULT && prot_en && prediv_q) |=> ($stable(mult_q) && err_q);
  endproperty
  mult_under_prediv_chk: assert property (p_mult_prediv);

  // R7
  property p_prediv_early;
    @(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL && bus_wdata[0] && !prediv_q && !lock_stat_i)
      |=> (!prediv_q && $stable(pwroff_q) && err_q);
  endproperty
  prediv_before_lock_chk: assert property (p_prediv_early);

  // R9
  property p_err_sticky;
    @(posedge clk) disable iff (!rst_n)
      (err_q && !(bus_wr && bus_addr == A_CLR && bus_wdata[0])) |=> err_q;
  endproperty
  err_sticky_chk: assert property (p_err_sticky);
endmodule

// File: rtl/pll_lock_track.sv
`timescale 1ns/1ps
module pll_lock_track #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  input  logic mult_acc_i,
  output logic lock_q,
  output logic lock_rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   armed_q;

  // Synchronizer chain for the asynchronous lock input.
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= lock_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign lock_rise_o = sync_q[SYNC_STAGES-1] && !prev_q;

  // An accepted write re-arms and clears; it wins over a coincident edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (mult_acc_i) begin
      lock_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (lock_rise_o && armed_q) begin
      lock_q  <= 1'b1;
      armed_q <= 1'b0;
    end
  end

  // R3
  property p_clear;
    @(posedge clk) disable iff (!rst_n) mult_acc_i |=> !lock_q;
  endproperty
  lock_clear_chk: assert property (p_clear);

  // R3
  property p_cause;
    @(posedge clk) disable iff (!rst_n) $rose(lock_q) |-> $past(lock_rise_o);
  endproperty
  lock_cause_chk: assert property (p_cause);

  // R10
  property p_collide;
    @(posedge clk) disable iff (!rst_n) (mult_acc_i && lock_rise_o) |=> (!lock_q && armed_q);
  endproperty
  write_wins_chk: assert property (p_collide);
endmodule

// File: rtl/pll_mode_sel.sv
`timescale 1ns/1ps
module pll_mode_sel
  import pll_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              prediv_i,
  input  logic              pwroff_i,
  input  logic              locked_i,
  output clk_mode_e         mode_o,
  output logic [MULT_W-1:0] num_o,
  output logic [1:0]        den_o,
  output logic              bypass_o
);
  always_comb begin
    if (pwroff_i)                         mode_o = MODE_OFF;
    else if (locked_i && mult_i != '0)    mode_o = MODE_PLL;
    else                                  mode_o = MODE_BYPASS;
    num_o    = ratio_num(mode_o, mult_i);
    den_o    = ratio_den(prediv_i);
    bypass_o = (mode_o == MODE_BYPASS);
  end

  // R8
  property p_off_zero;
    @(posedge clk) disable iff (!rst_n) pwroff_i |-> (mult_i == '0);
  endproperty
  off_needs_zero_chk: assert property (p_off_zero);

  // R3
  property p_wait_lock;
    @(posedge clk) disable iff (!rst_n) !locked_i |-> (num_o == MULT_W'(1));
  endproperty
  bypass_until_lock_chk: assert property (p_wait_lock);
endmodule

// File: rtl/pll_mode_seq.sv
`timescale 1ns/1ps
module pll_mode_seq
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              prot_en,
  input  logic              lock_in,
  output logic [1:0]        mode_o,
  output logic [MULT_W-1:0] ratio_num_o,
  output logic [1:0]        ratio_den_o,
  output logic              bypass_o,
  output logic              locked_o,
  output logic              err_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              prediv_o,
  output logic              pwroff_o
);
  logic      mult_acc_w;
  logic      lock_rise_w;
  clk_mode_e mode_w;

  pll_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .prot_en    (prot_en),
    .lock_stat_i(locked_o),
    .mult_q     (mult_o),
    .prediv_q   (prediv_o),
    .pwroff_q   (pwroff_o),
    .err_q      (err_o),
    .mult_acc_o (mult_acc_w)
  );

  pll_lock_track #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_in    (lock_in),
    .mult_acc_i (mult_acc_w),
    .lock_q     (locked_o),
    .lock_rise_o(lock_rise_w)
  );

  pll_mode_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .mult_i   (mult_o),
    .prediv_i (prediv_o),
    .pwroff_i (pwroff_o),
    .locked_i (locked_o),
    .mode_o   (mode_w),
    .num_o    (ratio_num_o),
    .den_o    (ratio_den_o),
    .bypass_o (bypass_o)
  );

  assign mode_o = mode_w;

  // R2
  property p_pll_ratio;
    @(posedge clk) disable iff (!rst_n) (mode_o == MODE_PLL) |-> (ratio_num_o == mult_o && locked_o);
  endproperty
  pll_ratio_chk: assert property (p_pll_ratio);
endmodule

// File: tb/pll_mode_seq_bench.sv
`timescale 1ns/1ps
module pll_mode_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       prot_en = 1'b0;
  logic       lock_in = 1'b0;
  logic [1:0] mode_o;
  logic [3:0] ratio_num_o;
  logic [1:0] ratio_den_o;
  logic       bypass_o, locked_o, err_o, prediv_o, pwroff_o;
  logic [3:0] mult_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pll_mode_seq u_pll_mode_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .prot_en(prot_en), .lock_in(lock_in),
    .mode_o(mode_o), .ratio_num_o(ratio_num_o), .ratio_den_o(ratio_den_o),
    .bypass_o(bypass_o), .locked_o(locked_o), .err_o(err_o),
    .mult_o(mult_o), .prediv_o(prediv_o), .pwroff_o(pwroff_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic clear_err();
    wr(2'd2, 8'h01);
    chk("R9 error cleared", err_o, 0);
  endtask

  // Raise lock_in and check the three-edge latency of locked_o.
  task automatic raise_lock(input string tag);
    @(negedge clk);
    lock_in = 1'b1;
    repeat (2) @(negedge clk);
    chk({tag, " locked not yet"}, locked_o, 0);
    @(negedge clk);
    chk({tag, " locked now"}, locked_o, 1);
  endtask

  task automatic drop_lock();
    @(negedge clk);
    lock_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_o, 1);
    chk("R1 mult", mult_o, 0);
    chk("R1 prediv", prediv_o, 0);
    chk("R1 pwroff", pwroff_o, 0);
    chk("R1 num", ratio_num_o, 1);
    chk("R1 den", ratio_den_o, 2);
    chk("R1 bypass", bypass_o, 1);
    chk("R1 locked", locked_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic t_protect();
    prot_en = 1'b0;
    wr(2'd0, 8'h05);
    chk("R4 mult unchanged", mult_o, 0);
    chk("R4 no error", err_o, 0);
    prot_en = 1'b1;
  endtask

  task automatic t_reserved();
    wr(2'd0, 8'h0C);
    chk("R5 mult unchanged", mult_o, 0);
    chk("R5 error set", err_o, 1);
    wr(2'd0, 8'h0F);
    chk("R5 code 15 ignored", mult_o, 0);
    wr(2'd2, 8'h00);
    chk("R9 zero write keeps error", err_o, 1);
    clear_err();
  endtask

  task automatic t_lock_seq();
    wr(2'd0, 8'h04);
    chk("R3 mult stored", mult_o, 4);
    chk("R3 bypass before lock", mode_o, 1);
    chk("R3 num before lock", ratio_num_o, 1);
    raise_lock("R3");
    chk("R2 pll mode", mode_o, 2);
    chk("R2 num x4", ratio_num_o, 4);
    chk("R2 den 2", ratio_den_o, 2);
    chk("R2 bypass low", bypass_o, 0);
    wr(2'd1, 8'h01);
    chk("R2 prediv accepted", prediv_o, 1);
    chk("R2 den 1", ratio_den_o, 1);
    chk("R2 num kept", ratio_num_o, 4);
    wr(2'd0, 8'h06);
    chk("R6 mult unchanged", mult_o, 4);
    chk("R6 error set", err_o, 1);
    clear_err();
    wr(2'd1, 8'h00);
    chk("R2 den back to 2", ratio_den_o, 2);
    drop_lock();
  endtask

  task automatic t_prediv_early();
    wr(2'd0, 8'h03);
    chk("R3 lock cleared by write", locked_o, 0);
    chk("R3 bypass after rewrite", mode_o, 1);
    wr(2'd1, 8'h01);
    chk("R7 prediv unchanged", prediv_o, 0);
    chk("R7 error set", err_o, 1);
    clear_err();
    raise_lock("R3 relock");
    chk("R2 num x3", ratio_num_o, 3);
    drop_lock();
  endtask

  task automatic t_pwroff();
    wr(2'd1, 8'h02);
    chk("R8 pwroff refused", pwroff_o, 0);
    chk("R8 error set", err_o, 1);
    chk("R8 mode kept", mode_o, 2);
    clear_err();
    wr(2'd0, 8'h00);
    chk("R2 code 0 bypass", mode_o, 1);
    wr(2'd1, 8'h02);
    chk("R8 pwroff accepted", pwroff_o, 1);
    chk("R8 mode off", mode_o, 0);
    chk("R8 bypass low", bypass_o, 0);
    chk("R8 num 1", ratio_num_o, 1);
    chk("R8 den 2", ratio_den_o, 2);
    wr(2'd0, 8'h02);
    chk("R8 mult refused in off", mult_o, 0);
    chk("R8 error in off", err_o, 1);
    clear_err();
    wr(2'd1, 8'h00);
    chk("R8 leave off", mode_o, 1);
  endtask

  task automatic t_collide();
    @(negedge clk);
    lock_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h05;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R10 mult stored", mult_o, 5);
    repeat (4) @(negedge clk);
    chk("R10 write wins", locked_o, 0);
    chk("R10 still bypass", mode_o, 1);
    drop_lock();
    raise_lock("R10 later edge");
    chk("R10 pll after relock", mode_o, 2);
    chk("R10 num x5", ratio_num_o, 5);
    drop_lock();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_protect();
    t_reserved();
    t_lock_seq();
    t_prediv_early();
    t_pwroff();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule